// File: doc/BRIEF.md
# I2C Clock Period Generator

This block times the serial clock of an I2C controller. It drives SCL low through an open-drain pull-down and holds it there for a programmable low count. It then releases the line and starts the high count only once the synchronized SCL input reads high, so rise time and clock stretching by a target add to the period instead of eating into it. The same high count sets the START hold, the repeated-START setup and the STOP setup, which is the time between SCL being seen high and SDA being released.

A byte engine steers the block with a two-bit command and waits for `ready` between steps. In the parked state SCL is held low and the low time has already been met. A BIT command runs one clock pulse. `sample_stb` marks the first cycle of the high phase, when the shifter samples SDA. `drive_stb` marks the cycle SCL is pulled low again, after which the shifter may change SDA. The block drives SDA only for START, repeated START and STOP.

Each count is 9 bits wide: 8 bits from a count byte plus one extension bit. The prescale select makes one count worth one or two clocks.

Top module: `scl_period_gen`

## Requirements
- R1: The effective low count is {lo_msb, lo_lsb}, and a count of 0 acts as 1. SCL stays pulled low for max(count × D, 3) clocks before `ready` rises, where D is the clocks per count. The floor of 3 is the synchronizer latency needed to see the line low.
- R2: The effective high count is {hi_msb, hi_lsb}, and a count of 0 acts as 1. From the cycle `sample_stb` is high to the cycle SCL is pulled low again is exactly count × D clocks.
- R3: With the extension parameter off, lo_msb and hi_msb are ignored and each count is at most 255.
- R4: D is 1 when `slow` is 0 and 2 when `slow` is 1, and it scales every period in R1, R2, R6, R7 and R8.
- R5: After a BIT command releases SCL, the high phase starts exactly 3 clocks after the SCL input goes high. While a target holds SCL low, the block waits without limit.
- R6: Command 1 (START) while idle pulls SDA low. After high count × D clocks it pulls SCL low. SDA stays low through that low period, and SDA is released in the same cycle `ready` rises.
- R7: Command 1 while parked is a repeated START. SCL is released with SDA released. 3 + high × D clocks later SDA is pulled low, and high × D clocks after that SCL is pulled low for the R1 low period.
- R8: Command 3 (STOP) while parked pulls SDA low and releases SCL in the same cycle. SDA is released 3 + high × D clocks later, and the block is then idle with `ready` high.
- R9: Command 0 is NONE. BIT (2) and STOP (3) have no effect while idle. Every command has no effect while `ready` is low.
- R10: While `en` is low, the next clock releases SCL and SDA and the block returns to idle with `ready` high.
- R11: After reset, SCL and SDA are released, `ready` is high and both strobes are low.
- R12: `sample_stb` is high for exactly one cycle per BIT command. `drive_stb` is high in exactly the cycle a BIT command pulls SCL low. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request; low forces idle |
| cmd | input | 2 | 0 none, 1 START, 2 BIT, 3 STOP |
| lo_lsb | input | 8 | Low count, bits 7:0 |
| hi_lsb | input | 8 | High count, bits 7:0 |
| lo_msb | input | 1 | Low count, bit 8 |
| hi_msb | input | 1 | High count, bit 8 |
| slow | input | 1 | Prescale select: 0 gives one clock per count, 1 gives two |
| scl_in | input | 1 | SCL line as read from the pad |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low, for bus conditions only |
| ready | output | 1 | Idle or parked; accepts a command |
| sample_stb | output | 1 | First cycle of a bit's high phase |
| drive_stb | output | 1 | SCL pulled low at the end of a bit |

## Verification
The bench sweeps low and high counts of 0, 1, small values and values with bit 8 set, under both prescale settings. It measures each phase length in clocks against count × D.

Zero and one counts expose a design that times an empty phase, or that leaves the low phase before the synchronizer has seen the line fall; such a design would then read stale high samples and run a short high phase. Bit-8 counts catch a dropped extension bit, and a second instance with the extension off catches one that is wrongly honoured.

A held SCL during the wait catches a design that starts the high count at release rather than at the sensed rise. Commands injected mid-phase and while idle, and `en` dropped during a long low phase, catch state corruption.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_BIT   = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,      // bus released
    ST_PARK,      // SCL held low, low time met
    ST_SHOLD,     // START hold: SDA low, SCL high
    ST_SLOW,      // low period after START, SDA still low
    ST_RWAIT,     // repeated START: waiting for SCL high
    ST_RSETUP,    // repeated START setup with SDA high
    ST_BWAIT,     // bit: waiting for SCL high
    ST_BHIGH,     // bit: high period
    ST_BLOW,      // bit: low period
    ST_PWAIT,     // STOP: waiting for SCL high, SDA low
    ST_PHIGH      // STOP setup before SDA release
  } st_e;

endpackage

// File: rtl/sclgen_sync.sv
module sclgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sclgen_compose.sv
module sclgen_compose #(
  parameter int LSB_W   = 8,
  parameter bit HAS_EXT = 1'b1,
  localparam int CNT_W  = LSB_W + 1
) (
  input  logic [LSB_W-1:0] lsb,
  input  logic             msb,
  output logic [CNT_W-1:0] count
);

  generate
    if (HAS_EXT) begin : g_ext
      assign count = {msb, lsb};
    end else begin : g_noext
      assign count = {msb & 1'b0, lsb};
    end
  endgenerate

endmodule

// File: rtl/sclgen_timer.sv
module sclgen_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             slow,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic             pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             tick;
  logic             last;
  logic             hit;

  assign tick   = !slow || pre_q;
  assign last   = ({1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};
  assign hit    = run && tick && last;
  assign expire = run && (done_q || hit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (run) begin
      done_q <= done_q || hit;
      if (tick) begin
        pre_q <= 1'b0;
        if (!last) cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import sclgen_pkg::*;
#(
  parameter int LSB_W       = 8,
  parameter bit HAS_EXT     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       cmd,
  input  logic [LSB_W-1:0] lo_lsb,
  input  logic [LSB_W-1:0] hi_lsb,
  input  logic             lo_msb,
  input  logic             hi_msb,
  input  logic             slow,
  input  logic             scl_in,
  output logic             scl_pull,
  output logic             sda_pull,
  output logic             ready,
  output logic             sample_stb,
  output logic             drive_stb
);

  localparam int CNT_W = LSB_W + 1;

  st_e              state_q, nxt;
  cmd_e             op;
  logic             scl_hi;
  logic [CNT_W-1:0] lo_cnt, hi_cnt, limit;
  logic             low_phase, timed, expire, restart;

  assign op = cmd_e'(cmd);

  sclgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (scl_in),
    .q   (scl_hi)
  );

  sclgen_compose #(.LSB_W(LSB_W), .HAS_EXT(HAS_EXT)) u_lo (
    .lsb   (lo_lsb),
    .msb   (lo_msb),
    .count (lo_cnt)
  );

  sclgen_compose #(.LSB_W(LSB_W), .HAS_EXT(HAS_EXT)) u_hi (
    .lsb   (hi_lsb),
    .msb   (hi_msb),
    .count (hi_cnt)
  );

  assign low_phase = (state_q == ST_SLOW) || (state_q == ST_BLOW);
  assign timed     = low_phase || (state_q == ST_SHOLD) || (state_q == ST_RSETUP) ||
                     (state_q == ST_BHIGH) || (state_q == ST_PHIGH);
  assign limit     = low_phase ? lo_cnt : hi_cnt;
  assign restart   = (nxt != state_q);

  sclgen_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart),
    .run    (timed),
    .slow   (slow),
    .limit  (limit),
    .expire (expire)
  );

  // Low phases end only once the synchronized line reads low as well.
  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE:   if (op == CMD_START) nxt = ST_SHOLD;
      ST_PARK: begin
        case (op)
          CMD_START: nxt = ST_RWAIT;
          CMD_BIT:   nxt = ST_BWAIT;
          CMD_STOP:  nxt = ST_PWAIT;
          default:   nxt = ST_PARK;
        endcase
      end
      ST_SHOLD:  if (expire)            nxt = ST_SLOW;
      ST_SLOW:   if (expire && !scl_hi) nxt = ST_PARK;
      ST_RWAIT:  if (scl_hi)            nxt = ST_RSETUP;
      ST_RSETUP: if (expire)            nxt = ST_SHOLD;
      ST_BWAIT:  if (scl_hi)            nxt = ST_BHIGH;
      ST_BHIGH:  if (expire)            nxt = ST_BLOW;
      ST_BLOW:   if (expire && !scl_hi) nxt = ST_PARK;
      ST_PWAIT:  if (scl_hi)            nxt = ST_PHIGH;
      ST_PHIGH:  if (expire)            nxt = ST_IDLE;
      default:                          nxt = ST_IDLE;
    endcase
    if (!en) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      scl_pull   <= 1'b0;
      sda_pull   <= 1'b0;
      ready      <= 1'b1;
      sample_stb <= 1'b0;
      drive_stb  <= 1'b0;
    end else begin
      state_q    <= nxt;
      scl_pull   <= (nxt == ST_SLOW) || (nxt == ST_BLOW) || (nxt == ST_PARK);
      sda_pull   <= (nxt == ST_SHOLD) || (nxt == ST_SLOW) ||
                    (nxt == ST_PWAIT) || (nxt == ST_PHIGH);
      ready      <= (nxt == ST_IDLE) || (nxt == ST_PARK);
      sample_stb <= (nxt == ST_BHIGH) && (state_q != ST_BHIGH);
      drive_stb  <= (nxt == ST_BLOW) && (state_q != ST_BLOW);
    end
  end

endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_pull,
  input logic sda_pull,
  input logic ready,
  input logic sample_stb,
  input logic drive_stb
);

  assert_sample_released_R5: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (!scl_pull && !sda_pull));

  assert_strobes_apart_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_stb, drive_stb}));

  assert_bit_fall_R12: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_pull) && !sda_pull) |-> drive_stb);

  assert_start_order_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_pull) && sda_pull) |-> $past(sda_pull));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_pull) && !scl_pull) |-> ready);

  assert_disable_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_pull && !sda_pull && ready));

endmodule

bind scl_period_gen sclgen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull),
  .ready      (ready),
  .sample_stb (sample_stb),
  .drive_stb  (drive_stb)
);

// File: tb/sim_scl_period_gen.sv
module sim_scl_period_gen;

  logic       clk = 1'b0;
  logic       rst, en, lo_msb, hi_msb, slow, hold;
  logic [1:0] cmd, cmd1;
  logic [7:0] lo_lsb, hi_lsb;
  wire        scl_pull, sda_pull, ready, sample_stb, drive_stb;
  wire        u1_scl, u1_sda, u1_ready, u1_sstb, u1_dstb;
  wire        line0 = !scl_pull && !hold;
  wire        line1 = !u1_scl;
  int         nchk = 0, nerr = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  scl_period_gen u0 (
    .clk(clk), .rst(rst), .en(en), .cmd(cmd), .lo_lsb(lo_lsb), .hi_lsb(hi_lsb),
    .lo_msb(lo_msb), .hi_msb(hi_msb), .slow(slow), .scl_in(line0),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .ready(ready),
    .sample_stb(sample_stb), .drive_stb(drive_stb));

  scl_period_gen #(.HAS_EXT(1'b0)) u1 (
    .clk(clk), .rst(rst), .en(en), .cmd(cmd1), .lo_lsb(lo_lsb), .hi_lsb(hi_lsb),
    .lo_msb(lo_msb), .hi_msb(hi_msb), .slow(slow), .scl_in(line1),
    .scl_pull(u1_scl), .sda_pull(u1_sda), .ready(u1_ready),
    .sample_stb(u1_sstb), .drive_stb(u1_dstb));

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int per(int n, int d);
    return ((n == 0) ? 1 : n) * d;
  endfunction

  function automatic int lowp(int n, int d);
    int p = per(n, d);
    return (p < 3) ? 3 : p;
  endfunction

  task automatic step;
    @(negedge clk);
  endtask

  task automatic issue(logic [1:0] c);
    @(negedge clk); cmd = c;
    @(negedge clk); cmd = 2'd0;
  endtask

  task automatic set_cfg(int lo, int hi, int s);
    lo_lsb = lo[7:0]; lo_msb = lo[8];
    hi_lsb = hi[7:0]; hi_msb = hi[8];
    slow   = s[0];
  endtask

  task automatic do_start(int h, int l);
    int c;
    issue(2'd1);
    c = 0; while (sda_pull && !scl_pull && c < 5000) begin c++; step; end
    chk("R6", "start hold", c, h);
    c = 0; while (sda_pull && scl_pull && !ready && c < 5000) begin c++; step; end
    chk("R6", "start low with SDA held", c, l);
    chk("R6", "parked after start", {29'd0, ready, scl_pull, sda_pull}, 6);
  endtask

  task automatic do_bit(int k, int h, int l, int d);
    int c, s;
    hold = (k > 0);
    issue(2'd2);
    c = 0;
    while (!sample_stb && c < 5000) begin
      if (c == k) hold = 1'b0;
      c++; step;
    end
    chk("R5", "release to high phase", c, k + 3);
    c = 0; s = 0;
    while (!scl_pull && c < 5000) begin
      if (sample_stb) s++;
      c++; step;
    end
    chk((d == 2) ? "R4" : "R2", "high period", c, h);
    chk("R12", "sample strobe cycles", s, 1);
    chk("R12", "drive strobe at fall", int'(drive_stb), 1);
    c = 0; while (scl_pull && !ready && c < 5000) begin c++; step; end
    chk((d == 2) ? "R4" : "R1", "bit low period", c, l);
    chk("R12", "drive strobe one cycle", int'(drive_stb), 0);
  endtask

  task automatic do_stop(int h);
    int c;
    issue(2'd3);
    c = 0; while (sda_pull && !scl_pull && c < 5000) begin c++; step; end
    chk("R8", "stop setup", c, 3 + h);
    chk("R8", "idle after stop", {29'd0, ready, scl_pull, sda_pull}, 4);
  endtask

  task automatic do_rstart(int h, int l);
    int c;
    issue(2'd1);
    c = 0; while (!sda_pull && !scl_pull && c < 5000) begin c++; step; end
    chk("R7", "repeated start setup", c, 3 + h);
    c = 0; while (sda_pull && !scl_pull && c < 5000) begin c++; step; end
    chk("R7", "repeated start hold", c, h);
    c = 0; while (sda_pull && scl_pull && !ready && c < 5000) begin c++; step; end
    chk("R7", "repeated start low", c, l);
  endtask

  initial begin
    int lo_v[4];
    int hi_v[4];
    int c;
    lo_v = '{0, 1, 3, 256};
    hi_v = '{0, 1, 4, 257};
    rst = 1'b1; en = 1'b1; cmd = 2'd0; cmd1 = 2'd0; hold = 1'b0;
    set_cfg(3, 4, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    step;
    // R11: reset state
    chk("R11", "scl released", int'(scl_pull), 0);
    chk("R11", "sda released", int'(sda_pull), 0);
    chk("R11", "ready", int'(ready), 1);
    chk("R11", "strobes", int'(sample_stb) + int'(drive_stb), 0);

    // R9: BIT and STOP ignored while idle
    issue(2'd2);
    for (int i = 0; i < 4; i++) begin
      chk("R9", "bit while idle", {29'd0, ready, scl_pull, sda_pull}, 4);
      step;
    end
    issue(2'd3);
    for (int i = 0; i < 4; i++) begin
      chk("R9", "stop while idle", {29'd0, ready, scl_pull, sda_pull}, 4);
      step;
    end

    // Sweep of counts and prescale (R1, R2, R4 .. R8)
    for (int s = 0; s < 2; s++) begin
      for (int li = 0; li < 4; li++) begin
        for (int hj = 0; hj < 4; hj++) begin
          int d, h, l;
          d = s + 1;
          h = per(hi_v[hj], d);
          l = lowp(lo_v[li], d);
          set_cfg(lo_v[li], hi_v[hj], s);
          do_start(h, l);
          do_bit(0, h, l, d);
          do_bit(5, h, l, d);
          do_rstart(h, l);
          do_bit(0, h, l, d);
          do_stop(h);
        end
      end
    end

    // R9: a command during a busy phase changes nothing
    set_cfg(20, 4, 0);
    do_start(4, 20);
    issue(2'd2);
    c = 0; while (!scl_pull && c < 5000) begin c++; step; end
    cmd = 2'd3; step; cmd = 2'd0;
    c = 1; while (scl_pull && !ready && c < 5000) begin c++; step; end
    chk("R9", "low period with stray command", c, 20);
    chk("R9", "still parked", {29'd0, ready, scl_pull, sda_pull}, 6);
    do_stop(4);

    // R10: dropping en mid low phase
    set_cfg(256, 4, 0);
    do_start(4, 256);
    issue(2'd2);
    c = 0; while (!scl_pull && c < 5000) begin c++; step; end
    repeat (10) step;
    en = 1'b0; step;
    chk("R10", "released and idle", {29'd0, ready, scl_pull, sda_pull}, 4);
    en = 1'b1; step;
    set_cfg(2, 3, 0);
    do_start(3, 3);
    do_stop(3);

    // R3: extension bits honoured by u0, ignored by u1
    set_cfg(258, 259, 0);
    @(negedge clk); cmd1 = 2'd1;
    @(negedge clk); cmd1 = 2'd0;
    c = 0; while (u1_sda && !u1_scl && c < 5000) begin c++; step; end
    chk("R3", "hold without extension", c, 3);
    c = 0; while (u1_sda && u1_scl && !u1_ready && c < 5000) begin c++; step; end
    chk("R3", "low without extension", c, 3);
    @(negedge clk); cmd1 = 2'd3;
    @(negedge clk); cmd1 = 2'd0;
    c = 0; while (u1_sda && !u1_scl && c < 5000) begin c++; step; end
    chk("R3", "stop without extension", c, 6);
    do_start(259, 258);
    do_stop(259);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule